// File: doc/BRIEF.md
# Recirculating Shift-and-Copy Register Pair

The block holds two four-stage registers that move right together on a common shift enable. The primary register can be filled in parallel. Its lowest stage is its serial output. On each shift, that bit goes into the top stage of the secondary register. It can also go back into the primary register's own top stage. With that feedback on, four shifts copy the primary word into the secondary register and leave the primary word where it started. With the feedback off, new bits enter the primary register from an external serial input, and the old word is moved out into the secondary register.

Both registers are visible as 4-bit words at all times. Bit 3 of each word is the stage that receives the incoming bit. Bit 0 is the stage that leaves first, so a word moves out least significant bit first. A synchronous reset clears both registers. A parallel load writes only the primary register and takes priority over shifting.

Top module: `shift_copy_pair`

## Requirements
- R1: A high `rst` at a clock edge clears `word_a` and `word_b` to 0000, whatever the other inputs are.
- R2: With `rst` low and `load_en` high, the clock edge writes `load_word` into `word_a` and `word_b` holds, even if `shift_en` is high.
- R3: On a shift edge (`shift_en` high, `rst` and `load_en` low), each of `word_a[2:0]` takes the value of the bit one position above it before the edge.
- R4: On a shift edge with `recirc_en` high, `word_a[3]` takes the old `word_a[0]`.
- R5: On a shift edge with `recirc_en` low, `word_a[3]` takes `ser_in`.
- R6: On a shift edge, `word_b[3]` takes the old `word_a[0]`, and `word_b[2:0]` takes the old `word_b[3:1]`.
- R7: With `rst`, `load_en` and `shift_en` all low, both words hold their values.
- R8: Start from `word_b` cleared. After four shift edges with `recirc_en` high, `word_a` is unchanged and `word_b` equals it. After four shift edges with `recirc_en` low and `ser_in` at 0, `word_a` is 0000 and `word_b` holds the former `word_a`. Example: starting from 1101, with `recirc_en` high, one shift gives `word_a`=1110 and `word_b`=1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears both registers |
| shift_en | input | 1 | Shift both registers one stage right |
| recirc_en | input | 1 | Feed the primary serial output back into the primary top stage |
| ser_in | input | 1 | External serial bit for the primary top stage when not recirculating |
| load_en | input | 1 | Parallel load of the primary register |
| load_word | input | 4 | Word written into the primary register |
| word_a | output | 4 | Primary register contents; bit 3 is the entry stage, bit 0 the serial output |
| word_b | output | 4 | Secondary register contents; bit 3 is the entry stage |

## Verification
The assertions check the single-edge rules on every cycle: reset clearing, load priority, the hold, the one-stage move of both registers, and which bit enters the primary top stage in each mode. The four-pulse results need a scenario to show them. These are restoring the word by recirculation, copying it into the secondary register, and draining the primary register to zero with the feedback off. The bench runs these scenarios and checks the outcome against the worked example words.

// File: rtl/shift_copy_pair.sv
module shift_copy_pair (
  input  logic       clk,
  input  logic       rst,
  input  logic       shift_en,
  input  logic       recirc_en,
  input  logic       ser_in,
  input  logic       load_en,
  input  logic [3:0] load_word,
  output logic [3:0] word_a,
  output logic [3:0] word_b
);
  logic tap;
  logic entry;

  assign tap   = word_a[0];
  assign entry = recirc_en ? tap : ser_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_a <= '0;
      word_b <= '0;
    end else if (load_en) begin
      word_a <= load_word;
    end else if (shift_en) begin
      word_a <= {entry, word_a[3:1]};
      word_b <= {tap, word_b[3:1]};
    end
  end
endmodule

// File: rtl/shift_copy_pair_chk.sv
module shift_copy_pair_chk (
  input logic       clk,
  input logic       rst,
  input logic       shift_en,
  input logic       recirc_en,
  input logic       ser_in,
  input logic       load_en,
  input logic [3:0] load_word,
  input logic [3:0] word_a,
  input logic [3:0] word_b
);
  logic shifting;
  assign shifting = shift_en && !load_en && !rst;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (word_a == 4'b0000 && word_b == 4'b0000));

  assert_load_wins_R2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (word_a == $past(load_word) && $stable(word_b)));

  assert_stage_move_R3: assert property (@(posedge clk) disable iff (rst)
    shifting |=> word_a[2:0] == $past(word_a[3:1]));

  assert_feedback_R4: assert property (@(posedge clk) disable iff (rst)
    (shifting && recirc_en) |=> word_a[3] == $past(word_a[0]));

  assert_serial_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (shifting && !recirc_en) |=> word_a[3] == $past(ser_in));

  assert_copy_path_R6: assert property (@(posedge clk) disable iff (rst)
    shifting |=> word_b == {$past(word_a[0]), $past(word_b[3:1])});

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !load_en) |=> ($stable(word_a) && $stable(word_b)));
endmodule

bind shift_copy_pair shift_copy_pair_chk u_chk (.*);

// File: tb/shift_copy_pair_bench.sv
module shift_copy_pair_bench;
  logic clk = 1'b0;
  logic rst = 1'b1, shift_en = 1'b0, recirc_en = 1'b0, ser_in = 1'b0, load_en = 1'b0;
  logic [3:0] load_word = '0;
  logic [3:0] word_a, word_b;

  int compared = 0;
  int mismatched = 0;
  bit qa[$];
  bit qb[$];

  always #10 clk = ~clk;

  shift_copy_pair u_shift_copy_pair (.*);

  function automatic logic [3:0] q2v(bit q[$]);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[3-i] = q[i];
    return v;
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(bit r, bit s, bit rc, bit si, bit l, logic [3:0] lw, string tag);
    bit a_out, nb;
    rst = r; shift_en = s; recirc_en = rc; ser_in = si; load_en = l; load_word = lw;
    if (r) begin
      qa = '{0, 0, 0, 0};
      qb = '{0, 0, 0, 0};
    end else if (l) begin
      qa = '{lw[3], lw[2], lw[1], lw[0]};
    end else if (s) begin
      a_out = qa.pop_back();
      nb = rc ? a_out : si;
      qa.push_front(nb);
      void'(qb.pop_back());
      qb.push_front(a_out);
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " word_a"}, word_a, q2v(qa));
    check({tag, " word_b"}, word_b, q2v(qb));
  endtask

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(1, 1, 1, 1, 1, 4'hF, "R1 reset");
    check("R1 reset a zero", word_a, 4'b0000);
    cyc(0, 0, 0, 0, 1, 4'b1101, "R2 load");
    check("R2 load value", word_a, 4'b1101);
    cyc(0, 1, 1, 0, 0, 4'h0, "R4 R3 R6 first shift");
    check("R4 example a", word_a, 4'b1110);
    check("R6 example b", word_b, 4'b1000);
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 1, 0, 4'h0, "R4 recirc shift");
    check("R8 recirc restores a", word_a, 4'b1101);
    check("R8 recirc copies b", word_b, 4'b1101);
    for (int i = 0; i < 3; i++) cyc(0, 0, i[0], 1, 0, 4'h0, "R7 idle hold");
    check("R7 hold a", word_a, 4'b1101);
    cyc(0, 1, 0, 1, 1, 4'b1011, "R2 load over shift");
    check("R2 load priority b", word_b, 4'b1101);
    cyc(1, 0, 0, 0, 0, 4'h0, "R1 reset");
    cyc(0, 0, 0, 0, 1, 4'b1011, "R2 load");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0, 4'h0, "R5 drain shift");
    check("R8 drain clears a", word_a, 4'b0000);
    check("R8 drain copies b", word_b, 4'b1011);
    cyc(0, 1, 0, 1, 0, 4'h0, "R5 serial 1");
    cyc(0, 1, 0, 0, 0, 4'h0, "R5 serial 0");
    cyc(0, 1, 0, 1, 0, 4'h0, "R5 serial 1");
    cyc(0, 1, 0, 1, 0, 4'h0, "R5 serial 1");
    check("R5 serial word", word_a, 4'b1101);
    cyc(1, 1, 0, 1, 1, 4'h7, "R1 reset over load");
    for (int i = 0; i < 300; i++) begin
      int unsigned r = $urandom;
      cyc(r[7:0] == 0, r[8], r[9], r[10], r[13:11] == 0, r[17:14], "R3 R6 mixed");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule